// File: doc/BRIEF.md
# Memory-Mapped GPIO Unit with Interrupt Cause Logic

This block is a register-mapped bank of general-purpose pins, 32 by default. Software reaches it through a plain word bus: an address, a write strobe, write data and read data that is available in the same cycle. For each pin it holds an output value, a direction bit, a blink enable and an input polarity invert. The pad inputs go through a two-stage synchronizer and then through the polarity invert. The result can be read back as a data-in word.

Each pin can raise an interrupt in two ways. The first is its level, which is the data-in bit gated by a level mask. The second is a latched edge, which is a sticky cause bit gated by an edge mask. The cause bits are cleared by writing zero to them. The per-pin causes are ORed together in groups of eight consecutive pins, and each group drives one summary interrupt output. A parameter sets the offset of the two mask registers. All blinking pins share one toggle signal, and a parameter sets its period in clock cycles.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every register reads zero. All `pad_oe` bits are 1, because a direction bit of 0 means output. `pad_out` and `irq_group` are zero.
- R2: Byte offsets: 0x00 output value, 0x04 direction, 0x08 blink enable and 0x0C polarity. All four read back what was written. An unmapped offset reads zero.
- R3: Direction bit 1 makes the pin an input, so its `pad_oe` bit is 0. Direction bit 0 drives `pad_oe` to 1. A non-blinking pin drives its output-value bit on `pad_out`.
- R4: The data-in word at offset 0x10 equals the pad level, delayed by two clock edges, XOR the polarity bits. A write to 0x10 has no effect.
- R5: A 0-to-1 transition of a data-in bit sets the edge cause bit of that pin, at offset 0x14. With polarity 0 a rising pad is caught and a falling pad is not. With polarity 1 a falling pad is caught and a rising pad is not.
- R6: A write to the edge cause register clears each bit written as 0 and keeps each bit written as 1. Cause bits stay set until they are cleared this way.
- R7: If an edge sets a cause bit in the same cycle that a write clears it, the bit ends up set.
- R8: The level cause of a pin is its data-in bit AND its level mask bit. It is not latched, so it drops as soon as the data-in bit falls.
- R9: The cause of a pin is its level cause OR (edge cause AND edge mask). `irq_group[g]` is the OR of the causes of pins 8g to 8g+7.
- R10: The edge mask is at byte offset 0x18 + MASK_OFS and the level mask is at 0x1C + MASK_OFS, with a default MASK_OFS of 0x20. When MASK_OFS is nonzero, offsets 0x18 and 0x1C are unmapped.
- R11: A pin with blink enabled drives a shared toggle on `pad_out` instead of its output value. The toggle inverts once every BLINK_CYCLES clock cycles, and all blinking pins show the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| pad_in | input | NPINS | Asynchronous pad levels |
| pad_out | output | NPINS | Output value for each pad |
| pad_oe | output | NPINS | Output driver enable for each pad |
| irq_group | output | NPINS/8 rounded up | One summary interrupt per group of eight pins |

## Verification
The bound assertions check the following on every cycle:
- Edge cause bits stay set when no write to the cause register occurs.
- A write to the cause register clears exactly the bits written as zero.
- A same-cycle edge always wins over a clear.
- A direction write shows up on `pad_oe`.
- Data-in tracks the pad delayed by two edges, XOR the polarity.
- The summary lines stay low while both masks are zero.

Some behaviours can only be shown by the bench's scenarios. These are:
- Which pad direction each polarity catches.
- A level interrupt dropping without any latch.
- The grouping of causes into the summary lines.
- The relocated mask offsets.
- The blink period.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int DW = 32;

  // rising transition of the polarity-corrected input
  function automatic logic [DW-1:0] rise_of(input logic [DW-1:0] cur, input logic [DW-1:0] prev);
    return cur & ~prev;
  endfunction

  // software write-zero-to-clear, then hardware set has priority
  function automatic logic [DW-1:0] cause_next(input logic [DW-1:0] cur, input logic wr,
                                               input logic [DW-1:0] keep, input logic [DW-1:0] hit);
    logic [DW-1:0] v;
    v = wr ? (cur & keep) : cur;
    return v | hit;
  endfunction

  // combined per-pin cause
  function automatic logic [DW-1:0] pin_cause(input logic [DW-1:0] din, input logic [DW-1:0] lmask,
                                              input logic [DW-1:0] ecause, input logic [DW-1:0] emask);
    return (din & lmask) | (ecause & emask);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_blink.sv
module gpio_blink #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tog
);
  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      tog <= 1'b0;
    end else if (cnt == LAST) begin
      cnt <= '0;
      tog <= ~tog;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int NPINS    = 32,
  parameter int AW       = 8,
  parameter int MASK_OFS = 32'h20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] din,
  input  logic [NPINS-1:0] edge_hit,
  output logic [NPINS-1:0] out_val,
  output logic [NPINS-1:0] dir_in,
  output logic [NPINS-1:0] blink_en,
  output logic [NPINS-1:0] pol,
  output logic [NPINS-1:0] ecause,
  output logic [NPINS-1:0] emask,
  output logic [NPINS-1:0] lmask
);
  localparam logic [AW-1:0] A_OUT   = AW'(32'h00);
  localparam logic [AW-1:0] A_DIR   = AW'(32'h04);
  localparam logic [AW-1:0] A_BLINK = AW'(32'h08);
  localparam logic [AW-1:0] A_POL   = AW'(32'h0C);
  localparam logic [AW-1:0] A_DIN   = AW'(32'h10);
  localparam logic [AW-1:0] A_CAUSE = AW'(32'h14);
  localparam logic [AW-1:0] A_EMASK = AW'(32'h18 + MASK_OFS);
  localparam logic [AW-1:0] A_LMASK = AW'(32'h1C + MASK_OFS);

  logic [NPINS-1:0] wd;
  logic             wr_cause;
  logic [DW-1:0]    cause_wide;

  assign wd       = bus_wdata[NPINS-1:0];
  assign wr_cause = bus_we && (bus_addr == A_CAUSE);

  always_comb begin
    cause_wide = cause_next(DW'(ecause), wr_cause, bus_wdata, DW'(edge_hit));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_val  <= '0;
      dir_in   <= '0;
      blink_en <= '0;
      pol      <= '0;
      ecause   <= '0;
      emask    <= '0;
      lmask    <= '0;
    end else begin
      ecause <= cause_wide[NPINS-1:0];
      if (bus_we) begin
        if (bus_addr == A_OUT)   out_val  <= wd;
        if (bus_addr == A_DIR)   dir_in   <= wd;
        if (bus_addr == A_BLINK) blink_en <= wd;
        if (bus_addr == A_POL)   pol      <= wd;
        if (bus_addr == A_EMASK) emask    <= wd;
        if (bus_addr == A_LMASK) lmask    <= wd;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if      (bus_addr == A_OUT)   bus_rdata[NPINS-1:0] = out_val;
    else if (bus_addr == A_DIR)   bus_rdata[NPINS-1:0] = dir_in;
    else if (bus_addr == A_BLINK) bus_rdata[NPINS-1:0] = blink_en;
    else if (bus_addr == A_POL)   bus_rdata[NPINS-1:0] = pol;
    else if (bus_addr == A_DIN)   bus_rdata[NPINS-1:0] = din;
    else if (bus_addr == A_CAUSE) bus_rdata[NPINS-1:0] = ecause;
    else if (bus_addr == A_EMASK) bus_rdata[NPINS-1:0] = emask;
    else if (bus_addr == A_LMASK) bus_rdata[NPINS-1:0] = lmask;
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_pkg::*;
#(
  parameter int NPINS        = 32,
  parameter int AW           = 8,
  parameter int MASK_OFS     = 32'h20,
  parameter int BLINK_CYCLES = 16,
  parameter int NGROUPS      = (NPINS + 7) / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_we,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NPINS-1:0]   pad_in,
  output logic [NPINS-1:0]   pad_out,
  output logic [NPINS-1:0]   pad_oe,
  output logic [NGROUPS-1:0] irq_group
);
  logic [NPINS-1:0] pad_s, din, din_q, edge_hit;
  logic [NPINS-1:0] out_val, dir_in, blink_en, pol, ecause, emask, lmask, cause;
  logic [DW-1:0]    rise_w, cause_w;
  logic             blink_tog;

  gpio_sync #(.W(NPINS)) u_sync (.clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_s));

  gpio_blink #(.CYCLES(BLINK_CYCLES)) u_blink (.clk(clk), .rst_n(rst_n), .tog(blink_tog));

  gpio_regfile #(.NPINS(NPINS), .AW(AW), .MASK_OFS(MASK_OFS)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .din(din), .edge_hit(edge_hit),
    .out_val(out_val), .dir_in(dir_in), .blink_en(blink_en), .pol(pol),
    .ecause(ecause), .emask(emask), .lmask(lmask)
  );

  assign din = pad_s ^ pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_q <= '0;
    else        din_q <= din;
  end

  always_comb begin
    rise_w  = rise_of(DW'(din), DW'(din_q));
    cause_w = pin_cause(DW'(din), DW'(lmask), DW'(ecause), DW'(emask));
  end
  assign edge_hit = rise_w[NPINS-1:0];
  assign cause    = cause_w[NPINS-1:0];

  assign pad_oe  = ~dir_in;
  assign pad_out = (blink_en & {NPINS{blink_tog}}) | (~blink_en & out_val);

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    localparam int LO = g * 8;
    localparam int HI = (LO + 7 < NPINS) ? LO + 7 : NPINS - 1;
    assign irq_group[g] = |cause[HI:LO];
  end
endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk #(
  parameter int NPINS    = 32,
  parameter int AW       = 8,
  parameter int MASK_OFS = 32'h20,
  parameter int NGROUPS  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [AW-1:0]      bus_addr,
  input logic               bus_we,
  input logic [31:0]        bus_wdata,
  input logic [NPINS-1:0]   pad_in,
  input logic [NPINS-1:0]   pad_oe,
  input logic [NPINS-1:0]   din,
  input logic [NPINS-1:0]   pol,
  input logic [NPINS-1:0]   edge_hit,
  input logic [NPINS-1:0]   ecause,
  input logic [NPINS-1:0]   emask,
  input logic [NPINS-1:0]   lmask,
  input logic [NGROUPS-1:0] irq_group
);
  localparam logic [AW-1:0] C_CAUSE = AW'(32'h14);
  localparam logic [AW-1:0] C_DIR   = AW'(32'h04);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == C_CAUSE) |=> ((ecause & $past(ecause)) == $past(ecause)));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == C_CAUSE && edge_hit == '0)
      |=> (ecause == ($past(ecause) & $past(bus_wdata[NPINS-1:0]))));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((ecause & $past(edge_hit)) == $past(edge_hit)));

  assert_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == C_DIR) |=> (pad_oe == ~$past(bus_wdata[NPINS-1:0])));

  assert_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (din == ($past(pad_in, 2) ^ pol)));

  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (emask == '0 && lmask == '0) |-> (irq_group == '0));
endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(
  .NPINS(NPINS), .AW(AW), .MASK_OFS(MASK_OFS), .NGROUPS(NGROUPS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .pad_in(pad_in), .pad_oe(pad_oe), .din(din), .pol(pol),
  .edge_hit(edge_hit), .ecause(ecause), .emask(emask), .lmask(lmask),
  .irq_group(irq_group)
);

// File: tb/gpio_irq_unit_tb.sv
`timescale 1ns/1ps
module gpio_irq_unit_tb;
  localparam int NP = 32;
  localparam int NG = 4;
  localparam int BLINK = 16;
  localparam int MOFS = 32'h20;
  localparam logic [7:0] R_OUT = 8'h00, R_DIR = 8'h04, R_BLK = 8'h08, R_POL = 8'h0C,
                         R_DIN = 8'h10, R_CAU = 8'h14,
                         R_EMK = 8'(32'h18 + MOFS), R_LMK = 8'(32'h1C + MOFS);

  logic clk = 0, rst_n = 0, we = 0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
  logic [NG-1:0] irq_group;
  int total = 0, fails = 0;
  logic [31:0] v;

  always #2.5 clk = ~clk;

  gpio_irq_unit #(.NPINS(NP), .AW(8), .MASK_OFS(MOFS), .BLINK_CYCLES(BLINK)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_group(irq_group));

  function automatic logic [NG-1:0] grp(input logic [31:0] c);
    logic [NG-1:0] r;
    for (int g = 0; g < NG; g++) r[g] = (((c >> (8 * g)) & 32'hFF) != 0);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    foreach (R_LIST[i]) ;
    rd(R_OUT, v); chk("R1 out", v, 0);
    rd(R_DIR, v); chk("R1 dir", v, 0);
    rd(R_CAU, v); chk("R1 cause", v, 0);
    rd(R_LMK, v); chk("R1 lmask", v, 0);
    chk("R1 oe", pad_oe, '1);
    chk("R1 out pins", pad_out, 0);
    chk("R1 irq", 32'(irq_group), 0);

    // R2 readback, unmapped
    wr(R_OUT, 32'hA5A5_0F0F); rd(R_OUT, v); chk("R2 out", v, 32'hA5A5_0F0F);
    wr(R_BLK, 32'h0000_0000); rd(R_BLK, v); chk("R2 blink", v, 0);
    rd(8'h24, v); chk("R2 unmapped", v, 0);
    // R3 direction and output value
    wr(R_DIR, 32'hFFFF_0000); rd(R_DIR, v); chk("R2 dir", v, 32'hFFFF_0000);
    chk("R3 oe", pad_oe, 32'h0000_FFFF);
    chk("R3 pad_out", pad_out, 32'hA5A5_0F0F);
    wr(R_DIR, 32'hFFFF_FFFF);

    // R4 data-in with polarity, read-only
    wr(R_POL, 32'h0000_00F0);
    @(negedge clk); pad_in = 32'h1234_5678; settle();
    rd(R_DIN, v); chk("R4 din", v, 32'h1234_5678 ^ 32'h0000_00F0);
    wr(R_DIN, 32'hFFFF_FFFF); rd(R_DIN, v); chk("R4 din ro", v, 32'h1234_5678 ^ 32'h0000_00F0);
    wr(R_POL, 0);
    @(negedge clk); pad_in = 0; settle();
    wr(R_CAU, 0); rd(R_CAU, v); chk("R6 clear all", v, 0);

    // R5 rising with pol 0
    @(negedge clk); pad_in[3] = 1; settle();
    rd(R_CAU, v); chk("R5 rise pol0", v, 32'h8);
    wr(R_CAU, 0);
    @(negedge clk); pad_in[3] = 0; settle();
    rd(R_CAU, v); chk("R5 fall ignored pol0", v, 0);
    // R5 falling with pol 1
    wr(R_POL, 32'h20); settle(); wr(R_CAU, 0);
    @(negedge clk); pad_in[5] = 1; settle();
    rd(R_CAU, v); chk("R5 rise ignored pol1", v, 0);
    @(negedge clk); pad_in[5] = 0; settle();
    rd(R_CAU, v); chk("R5 fall pol1", v, 32'h20);
    // R6 write-one keeps, sticky
    @(negedge clk); pad_in[3] = 1; settle();
    wr(R_CAU, 32'h8); rd(R_CAU, v); chk("R6 keep ones", v, 32'h8);
    repeat (5) @(negedge clk); rd(R_CAU, v); chk("R6 sticky", v, 32'h8);
    // R7 set wins over clear
    @(negedge clk); pad_in[7] = 1;
    @(negedge clk);
    wr(R_CAU, 0);
    rd(R_CAU, v); chk("R7 set wins", v, 32'h80);
    wr(R_CAU, 0);

    // R9 edge path through mask, group 1
    wr(R_POL, 0); settle();
    pad_in = 0; settle(); wr(R_CAU, 0);
    wr(R_EMK, 32'h0000_1000);
    @(negedge clk); pad_in[12] = 1; settle();
    chk("R9 edge irq grp1", 32'(irq_group), 32'h2);
    wr(R_EMK, 0); @(negedge clk); chk("R9 masked", 32'(irq_group), 0);
    wr(R_CAU, 0);

    // R8 level not latched
    wr(R_LMK, 32'h0100_0000);
    @(negedge clk); pad_in[24] = 1; settle();
    chk("R8 level high", 32'(irq_group), 32'h8);
    @(negedge clk); pad_in[24] = 0; settle();
    chk("R8 level drops", 32'(irq_group), 0);
    wr(R_LMK, 0); wr(R_CAU, 0);

    // R10 mask offsets
    wr(8'h18, 32'hFFFF_FFFF); rd(R_EMK, v); chk("R10 emask unmoved", v, 0);
    rd(8'h18, v); chk("R10 old offset unmapped", v, 0);
    wr(R_LMK, 32'h00FF_0000); rd(R_LMK, v); chk("R10 lmask", v, 32'h00FF_0000);
    wr(R_LMK, 0);

    // R11 blink
    wr(R_DIR, 0); wr(R_OUT, 0); wr(R_BLK, 32'h3);
    @(negedge clk); v = 32'(pad_out[0]);
    chk("R11 pins agree", 32'(pad_out[1]), v);
    repeat (BLINK) @(negedge clk);
    chk("R11 toggled", 32'(pad_out[0]), ~v & 1);
    chk("R11 pins agree2", 32'(pad_out[1]), ~v & 1);
    wr(R_BLK, 0); wr(R_OUT, 32'h3); chk("R11 off follows out", pad_out, 32'h3);
    wr(R_DIR, 32'hFFFF_FFFF);

    // random level-interrupt and data-in checks (R4, R8, R9)
    for (int it = 0; it < 40; it++) begin
      logic [31:0] p, q, m;
      p = $urandom; q = $urandom; m = $urandom & $urandom;
      wr(R_POL, q); wr(R_LMK, m); wr(R_EMK, 0);
      @(negedge clk); pad_in = p; settle();
      rd(R_DIN, v); chk("R4 rand din", v, p ^ q);
      chk("R9 rand level grp", 32'(irq_group), 32'(grp((p ^ q) & m)));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  localparam int R_LIST [1] = '{0};
endmodule